// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the interrupt control register of a small 8-bit microcontroller core. It watches three event sources. The first is a single external pin whose active edge can be selected. The second is a one-cycle pulse that marks the timer wrapping from 8'hFF to 8'h00. The third is a four-bit slice of an input port, which is compared against a snapshot that is taken each time software reads the port. Each event sets a sticky flag in the control register. Software reads the register, writes it, and clears flags by writing zeros.

The block has two outputs towards the core. An interrupt request is raised when the global enable is set and at least one source has both its flag and its enable set. A wake output is raised for a sleeping core whenever a source with its enable set is pending, and the global enable has no effect on it. The global enable therefore only decides whether the core branches to the vector after waking. The timer counter and the CPU are outside the block. A register write strobe, a port read strobe and the timer wrap pulse take their place.

Control register layout: bit 0 is the port-change flag, bit 1 the pin flag, bit 2 the timer flag, bit 3 the port-change enable, bit 4 the pin enable, bit 5 the timer enable, bit 6 a spare read/write bit, and bit 7 the global enable.

Top module: `irqf_ctrl`

## Requirements
- R1: Reset clears the control register to 8'h00, drives irqReq and wakeOut low, and sets the pin edge selection to rising, so the first rising pin edge after reset sets bit 1.
- R2: With edgeSelRise = 1, a rising edge on extPin sets bit 1 and a falling edge leaves bit 1 unchanged.
- R3: With edgeSelRise = 0, a falling edge on extPin sets bit 1 and a rising edge leaves bit 1 unchanged.
- R4: A valid pin edge sets bit 1 whether or not the pin enable (bit 4) is set.
- R5: A one-cycle pulse on timerWrap sets bit 2 at the next rising clock edge.
- R6: While the synchronized portHi differs from the snapshot taken at the last portRdEn, bit 0 is set. A portRdEn pulse stores the current synchronized value as the new snapshot.
- R7: Flags stay set until a register write puts 0 in them. A write with regWrEn loads all eight bits from regWrData at the next edge.
- R8: When a hardware event and a register write that clears the same flag occur in the same cycle, the flag ends up set and the other bits take the written value.
- R9: irqReq = bit7 AND ((bit0 AND bit3) OR (bit1 AND bit4) OR (bit2 AND bit5)).
- R10: wakeOut = asleep AND ((bit0 AND bit3) OR (bit1 AND bit4) OR (bit2 AND bit5)), whatever the value of bit 7.
- R11: extPin and portHi pass through two synchronizer flops. A change applied between clock edges becomes visible in the register after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | External interrupt pin, asynchronous |
| portHi | input | 4 | Port bits 7..4, asynchronous |
| timerWrap | input | 1 | One-cycle pulse when the timer wraps to zero |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| optWrEn | input | 1 | Edge selection write strobe |
| optWrData | input | 1 | New edge selection (1 = rising) |
| portRdEn | input | 1 | Software port read, takes the port snapshot |
| asleep | input | 1 | Core is in sleep mode |
| ctrlReg | output | 8 | Current control register value |
| edgeSelRise | output | 1 | Current edge selection |
| portRdData | output | 4 | Synchronized port value |
| irqReq | output | 1 | Interrupt request to the core |
| wakeOut | output | 1 | Wake request to a sleeping core |

## Verification
The assertions check on every cycle that flags drop only after a software write that clears them, that a timer pulse always leaves its flag set even against a clearing write, that the request never appears while the global enable is clear, and that the wake output appears only during sleep. Edge polarity selection, the exact synchronizer latency, snapshot behaviour on port reads, and the full truth table of request and wake can only be shown by the bench. The bench covers the truth table with a sweep over all 256 register values, each with sleep on and with sleep off.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int CTRL_W    = 8;
  localparam int PORT_FLAG = 0;
  localparam int PIN_FLAG  = 1;
  localparam int TMR_FLAG  = 2;
  localparam int PORT_EN   = 3;
  localparam int PIN_EN    = 4;
  localparam int TMR_EN    = 5;
  localparam int GLOBAL_EN = 7;

  // strobes from the detection logic to the register datapath
  typedef struct packed {
    logic pinEdge;
    logic tmrWrap;
    logic portDiff;
  } evtStrobes_t;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/irqf_detect.sv
module irqf_detect
  import irqf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portHi,
  input  logic              timerWrap,
  input  logic              portRdEn,
  input  logic              edgeSelRise,
  output logic [PORT_W-1:0] portNow,
  output evtStrobes_t       evt
);
  logic pinSync;
  logic pinPrev;
  logic [PORT_W-1:0] portSnap;
  logic riseSeen;
  logic fallSeen;

  irqf_sync #(.STAGES(SYNC_STAGES), .W(1)) i_pinSync (
    .clk(clk), .rstN(rstN), .asyncIn(extPin), .syncOut(pinSync)
  );

  irqf_sync #(.STAGES(SYNC_STAGES), .W(PORT_W)) i_portSync (
    .clk(clk), .rstN(rstN), .asyncIn(portHi), .syncOut(portNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         portSnap <= '0;
    else if (portRdEn) portSnap <= portNow;
  end

  assign riseSeen = pinSync & ~pinPrev;
  assign fallSeen = ~pinSync & pinPrev;

  always_comb begin
    evt          = '0;
    evt.pinEdge  = edgeSelRise ? riseSeen : fallSeen;
    evt.tmrWrap  = timerWrap;
    evt.portDiff = (portNow != portSnap);
  end
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobes_t       evt,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              optWrEn,
  input  logic              optWrData,
  input  logic              asleep,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              edgeRiseQ,
  output logic              irqReq,
  output logic              wakeOut
);
  logic [CTRL_W-1:0] ctrlNext;
  logic pending;

  always_comb begin
    ctrlNext = regWrEn ? regWrData : ctrlQ;
    if (evt.portDiff) ctrlNext[PORT_FLAG] = 1'b1;
    if (evt.pinEdge)  ctrlNext[PIN_FLAG]  = 1'b1;
    if (evt.tmrWrap)  ctrlNext[TMR_FLAG]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        edgeRiseQ <= 1'b1;
    else if (optWrEn) edgeRiseQ <= optWrData;
  end

  assign pending = (ctrlQ[PORT_FLAG] & ctrlQ[PORT_EN])
                 | (ctrlQ[PIN_FLAG]  & ctrlQ[PIN_EN])
                 | (ctrlQ[TMR_FLAG]  & ctrlQ[TMR_EN]);

  assign irqReq  = pending & ctrlQ[GLOBAL_EN];
  assign wakeOut = pending & asleep;
endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portHi,
  input  logic              timerWrap,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              optWrEn,
  input  logic              optWrData,
  input  logic              portRdEn,
  input  logic              asleep,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              edgeSelRise,
  output logic [PORT_W-1:0] portRdData,
  output logic              irqReq,
  output logic              wakeOut
);
  evtStrobes_t evt;

  irqf_detect #(.SYNC_STAGES(SYNC_STAGES), .PORT_W(PORT_W)) i_detect (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portHi(portHi),
    .timerWrap(timerWrap), .portRdEn(portRdEn), .edgeSelRise(edgeSelRise),
    .portNow(portRdData), .evt(evt)
  );

  irqf_regs i_regs (
    .clk(clk), .rstN(rstN), .evt(evt), .regWrEn(regWrEn),
    .regWrData(regWrData), .optWrEn(optWrEn), .optWrData(optWrData),
    .asleep(asleep), .ctrlQ(ctrlReg), .edgeRiseQ(edgeSelRise),
    .irqReq(irqReq), .wakeOut(wakeOut)
  );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       timerWrap,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic       asleep,
  input logic [7:0] ctrlReg,
  input logic       irqReq,
  input logic       wakeOut
);
  p_port_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlReg[0]) |-> $past(regWrEn && !regWrData[0]));
  p_pin_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlReg[1]) |-> $past(regWrEn && !regWrData[1]));
  p_tmr_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlReg[2]) |-> $past(regWrEn && !regWrData[2]));
  p_tmr_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    timerWrap |=> ctrlReg[2]);
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (timerWrap && regWrEn && !regWrData[2]) |=> ctrlReg[2]);
  p_no_irq_without_gie_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[7] |-> !irqReq);
  p_wake_only_asleep_r10: assert property (@(posedge clk) disable iff (!rstN)
    !asleep |-> !wakeOut);
endmodule

bind irqf_ctrl irqf_checker i_irqfChecker (
  .clk(clk), .rstN(rstN), .timerWrap(timerWrap), .regWrEn(regWrEn),
  .regWrData(regWrData), .asleep(asleep), .ctrlReg(ctrlReg),
  .irqReq(irqReq), .wakeOut(wakeOut)
);

// File: tb/test_irqf_ctrl.sv
module test_irqf_ctrl;
  logic       clk = 1'b0;
  logic       rstN;
  logic       extPin;
  logic [3:0] portHi;
  logic       timerWrap;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic       optWrEn;
  logic       optWrData;
  logic       portRdEn;
  logic       asleep;
  logic [7:0] ctrlReg;
  logic       edgeSelRise;
  logic [3:0] portRdData;
  logic       irqReq;
  logic       wakeOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  irqf_ctrl i_irqf_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portHi(portHi),
    .timerWrap(timerWrap), .regWrEn(regWrEn), .regWrData(regWrData),
    .optWrEn(optWrEn), .optWrData(optWrData), .portRdEn(portRdEn),
    .asleep(asleep), .ctrlReg(ctrlReg), .edgeSelRise(edgeSelRise),
    .portRdData(portRdData), .irqReq(irqReq), .wakeOut(wakeOut)
  );

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic [7:0] actual, logic [7:0] expected);
    checkCnt++;
    if (actual !== expected) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic writeCtrl(logic [7:0] v);
    regWrEn = 1'b1; regWrData = v;
    tick();
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; extPin = 1'b0; portHi = 4'h0; timerWrap = 1'b0;
    regWrEn = 1'b0; regWrData = 8'h00; optWrEn = 1'b0; optWrData = 1'b0;
    portRdEn = 1'b0; asleep = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 ctrl", ctrlReg, 8'h00);
    check("R1 irq/wake", {6'b0, irqReq, wakeOut}, 8'h00);
    check("R1 edge", {7'b0, edgeSelRise}, 8'h01);

    // R2 R11 rising edge, default polarity
    extPin = 1'b1;
    tick(2);
    check("R11 not after two edges", ctrlReg, 8'h00);
    tick();
    check("R2 R11 rising sets bit1", ctrlReg, 8'h02);
    writeCtrl(8'h00);
    extPin = 1'b0;
    tick(4);
    check("R2 falling ignored", ctrlReg, 8'h00);

    // R3 R4 falling polarity, pin enable clear
    optWrEn = 1'b1; optWrData = 1'b0;
    tick();
    optWrEn = 1'b0;
    check("R3 edge select", {7'b0, edgeSelRise}, 8'h00);
    extPin = 1'b1;
    tick(4);
    check("R3 rising ignored", ctrlReg, 8'h00);
    extPin = 1'b0;
    tick(3);
    check("R3 R4 falling sets bit1 without enable", ctrlReg, 8'h02);
    writeCtrl(8'h00);
    optWrEn = 1'b1; optWrData = 1'b1;
    tick();
    optWrEn = 1'b0;

    // R10 wake with global enable clear
    writeCtrl(8'h10);
    asleep = 1'b1;
    tick();
    check("R10 idle", {6'b0, irqReq, wakeOut}, 8'h00);
    extPin = 1'b1;
    tick(3);
    check("R10 wake without gie", {6'b0, irqReq, wakeOut}, 8'h01);
    check("R10 ctrl", ctrlReg, 8'h12);
    asleep = 1'b0;
    tick();
    check("R10 no wake awake", {7'b0, wakeOut}, 8'h00);
    writeCtrl(8'h00);

    // R5 timer wrap
    timerWrap = 1'b1;
    tick();
    timerWrap = 1'b0;
    check("R5 timer sets bit2", ctrlReg, 8'h04);
    // R7 sticky
    tick(5);
    check("R7 flag stays", ctrlReg, 8'h04);
    writeCtrl(8'hE4);
    check("R7 write keeps bit2 and loads others", ctrlReg, 8'hE4);
    writeCtrl(8'h00);
    check("R7 write clears", ctrlReg, 8'h00);

    // R8 hardware set wins
    timerWrap = 1'b1; regWrEn = 1'b1; regWrData = 8'h40;
    tick();
    timerWrap = 1'b0; regWrEn = 1'b0;
    check("R8 hw wins", ctrlReg, 8'h44);
    writeCtrl(8'h00);

    // R6 port change against snapshot
    portHi = 4'h5;
    tick(2);
    check("R6 R11 port not yet", ctrlReg, 8'h00);
    tick();
    check("R6 port change sets bit0", ctrlReg, 8'h01);
    check("R6 port read data", {4'b0, portRdData}, 8'h05);
    writeCtrl(8'h00);
    check("R6 re-sets while differing", ctrlReg, 8'h01);
    portRdEn = 1'b1;
    tick();
    portRdEn = 1'b0;
    writeCtrl(8'h00);
    tick();
    check("R6 snapshot taken", ctrlReg, 8'h00);
    portHi = 4'h4;
    tick(3);
    check("R6 second change", ctrlReg, 8'h01);
    portRdEn = 1'b1;
    tick();
    portRdEn = 1'b0;
    writeCtrl(8'h00);
    tick();
    check("R6 cleared", ctrlReg, 8'h00);

    // R9 R10 full sweep
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 2; s++) begin
        logic [7:0] val;
        logic pend;
        val = v[7:0];
        asleep = s[0];
        writeCtrl(val);
        pend = (val[0] & val[3]) | (val[1] & val[4]) | (val[2] & val[5]);
        check("R7 sweep load", ctrlReg, val);
        check("R9 R10 sweep irq/wake", {6'b0, irqReq, wakeOut},
              {6'b0, pend & val[7], pend & s[0]});
      end
    end
    asleep = 1'b0;
    writeCtrl(8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule